// File: doc/BRIEF.md
# MDIO Management Command Engine

This block lets software run Clause 22 management transactions against a PHY through three small host registers. Software loads a 16-bit word into the write-data register, then writes a command word. The command word holds a write-start flag, a read-start flag, a 5-bit PHY address and a 5-bit register number. The engine turns the command into one serial frame on the management clock and data lines. It returns the start flag to zero when the frame ends, so software learns of completion by polling the command register. After a read, the 16 bits returned by the PHY sit in the read-data register.

The management clock comes from the system clock through a divider. Each of its phases lasts `HALF_DIV` system cycles, and the clock rests low between frames. A frame is built from a run of `PREAMBLE_LEN` ones, then start bits, opcode, address fields, turnaround and data. The engine changes its output bit while the clock is low and samples the incoming line when the clock rises. A command that arrives while a frame is in flight is dropped.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset, `mdc` and `mdio_oe` are 0, and every host register reads 0. The host registers are at these `reg_addr` values: command 0, write data 1, read data 2.
- R2: In the command word, bit 14 starts a write. During a write, `mdio_oe` stays 1 for every clock period of the frame. The frame is sent MSB first and is made of: `PREAMBLE_LEN` ones, start bits 01, opcode 01, the PHY address (command bits 12:8), the register number (command bits 4:0), turnaround 10, and the write-data word.
- R3: In the command word, bit 13 starts a read. A read frame sends opcode 10 and otherwise carries the same header as a write. `mdio_oe` returns to 0 from the first turnaround bit to the end of the frame. The engine samples `mdio_i` on the last 16 rising edges of `mdc`, MSB first, and those bits then read back at address 2.
- R4: The command register reads back the stored command word, except that bits 14 and 13 show the live start flags. The active flag reads 1 from the clock edge that accepts the command. It clears after exactly 2*(`PREAMBLE_LEN`+32)*`HALF_DIV` system cycles.
- R5: `mdc` gives `PREAMBLE_LEN`+32 rising edges per frame, and each high and each low phase lasts `HALF_DIV` system cycles. Between frames `mdc` is 0.
- R6: A command write accepted while a frame is in flight has no effect. The frame on the pins is unchanged, no further frame follows, and the command register keeps the earlier word.
- R7: A command with both bit 14 and bit 13 set runs a read. While it is in flight, only bit 13 reads back as 1.
- R8: The frame uses the write-data value held when the command is accepted. Rewriting address 1 during a frame changes the value read back at address 1, but does not change the frame.
- R9: A command word with neither start flag is stored, with both flags reading 0, and no frame is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Host register write strobe |
| reg_addr | input | 2 | Host register select |
| reg_wdata | input | 16 | Host write value |
| reg_rdata | output | 16 | Host read value for `reg_addr` (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The bench builds the engine with `HALF_DIV` = 2 and `PREAMBLE_LEN` = 32. With these values a frame lasts 256 system cycles, which is short enough to sweep every PHY address and every register number through both writes and reads. A responder in the bench captures each frame bit by bit and checks it against a frame built arithmetically from the command. It also drives computed read data back on the line. The same small configuration also reaches the single-frame corner cases: commands that arrive while busy, the write-data register rewritten in mid-frame, a command with both flags set, and a command with neither flag.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int CMD_WR_BIT = 14;
    localparam int CMD_RD_BIT = 13;
    localparam int PHY_LSB    = 8;
    localparam int FIELD_W    = 5;
    localparam int WORD_W     = 16;
    // header after preamble: start(2) op(2) phy reg turnaround(2) data
    localparam int BODY_LEN   = 2 + 2 + 2 * FIELD_W + 2 + WORD_W;

    localparam logic [1:0] SOF_BITS = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] TA_WRITE = 2'b10;

    typedef enum logic [1:0] {
        SEL_CMD   = 2'd0,
        SEL_WDATA = 2'd1,
        SEL_RDATA = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_ev,
    output logic fall_ev
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          clk_lvl;
    } div_t;

    div_t div_d, div_q;
    logic term;

    always_comb begin
        div_d = div_q;
        term  = run && (div_q.cnt == LAST);
        if (!run) begin
            div_d.cnt     = '0;
            div_d.clk_lvl = 1'b0;
        end else if (term) begin
            div_d.cnt     = '0;
            div_d.clk_lvl = ~div_q.clk_lvl;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign mdc     = div_q.clk_lvl;
    assign rise_ev = term && !div_q.clk_lvl;
    assign fall_ev = term &&  div_q.clk_lvl;
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
#(
    parameter int PREAMBLE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_rd,
    input  logic [FIELD_W-1:0] phy,
    input  logic [FIELD_W-1:0] regno,
    input  logic [WORD_W-1:0] wdata,
    input  logic              rise_ev,
    input  logic              fall_ev,
    input  logic              mdio_i,
    output logic              busy,
    output logic              is_rd,
    output logic              done,
    output logic [WORD_W-1:0] cap,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam int FRAME_LEN = PREAMBLE_LEN + BODY_LEN;
    localparam int IW        = $clog2(FRAME_LEN);
    localparam int REL_IDX   = PREAMBLE_LEN + 4 + 2 * FIELD_W;
    localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_LEN - 1);
    localparam logic [IW-1:0] REL_POS  = IW'(REL_IDX);

    typedef struct packed {
        logic                 busy;
        logic                 is_rd;
        logic [IW-1:0]        idx;
        logic [FRAME_LEN-1:0] sh;
        logic [WORD_W-1:0]    cap;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        done  = 1'b0;
        if (!seq_q.busy) begin
            if (start) begin
                seq_d.busy  = 1'b1;
                seq_d.is_rd = start_rd;
                seq_d.idx   = '0;
                seq_d.sh    = {{PREAMBLE_LEN{1'b1}}, SOF_BITS,
                               start_rd ? OP_READ : OP_WRITE, phy, regno,
                               start_rd ? 2'b11 : TA_WRITE,
                               start_rd ? {WORD_W{1'b1}} : wdata};
            end
        end else begin
            if (rise_ev && seq_q.is_rd)
                seq_d.cap = {seq_q.cap[WORD_W-2:0], mdio_i};
            if (fall_ev) begin
                if (seq_q.idx == LAST_IDX) begin
                    seq_d.busy = 1'b0;
                    done       = 1'b1;
                end else begin
                    seq_d.idx = seq_q.idx + 1'b1;
                    seq_d.sh  = {seq_q.sh[FRAME_LEN-2:0], 1'b1};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy    = seq_q.busy;
    assign is_rd   = seq_q.is_rd;
    assign cap     = seq_q.cap;
    assign mdio_o  = seq_q.busy ? seq_q.sh[FRAME_LEN-1] : 1'b1;
    assign mdio_oe = seq_q.busy && (!seq_q.is_rd || (seq_q.idx < REL_POS));
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
    import mdio_pkg::*;
#(
    parameter int HALF_DIV     = 4,
    parameter int PREAMBLE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [1:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    typedef struct packed {
        logic [WORD_W-1:0] cmd;
        logic [WORD_W-1:0] wdata;
        logic [WORD_W-1:0] rdata;
        logic              wr_flag;
        logic              rd_flag;
    } host_t;

    host_t host_d, host_q;

    logic              seq_busy, seq_is_rd, seq_done;
    logic [WORD_W-1:0] seq_cap;
    logic              rise_ev, fall_ev;
    logic              cmd_hit, engine_busy, launch;
    logic              wr_flag_q, rd_flag_q;
    logic [WORD_W-1:0] cmd_q;

    always_comb begin
        host_d      = host_q;
        cmd_hit     = reg_wr_en && (reg_sel_e'(reg_addr) == SEL_CMD);
        engine_busy = host_q.wr_flag || host_q.rd_flag;
        launch      = cmd_hit && !engine_busy &&
                      (reg_wdata[CMD_WR_BIT] || reg_wdata[CMD_RD_BIT]);

        if (reg_wr_en && (reg_sel_e'(reg_addr) == SEL_WDATA))
            host_d.wdata = reg_wdata;

        if (cmd_hit && !engine_busy) begin
            host_d.cmd     = reg_wdata;
            host_d.rd_flag = reg_wdata[CMD_RD_BIT];
            host_d.wr_flag = reg_wdata[CMD_WR_BIT] && !reg_wdata[CMD_RD_BIT];
        end

        if (seq_done) begin
            host_d.wr_flag = 1'b0;
            host_d.rd_flag = 1'b0;
            if (seq_is_rd) host_d.rdata = seq_cap;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) host_q <= '0;
        else        host_q <= host_d;
    end

    assign wr_flag_q = host_q.wr_flag;
    assign rd_flag_q = host_q.rd_flag;
    assign cmd_q     = host_q.cmd;

    always_comb begin
        case (reg_sel_e'(reg_addr))
            SEL_CMD:   reg_rdata = {cmd_q[15], wr_flag_q, rd_flag_q, cmd_q[12:0]};
            SEL_WDATA: reg_rdata = host_q.wdata;
            SEL_RDATA: reg_rdata = host_q.rdata;
            default:   reg_rdata = '0;
        endcase
    end

    mdio_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (seq_busy),
        .mdc     (mdc),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev)
    );

    mdio_frame_seq #(.PREAMBLE_LEN(PREAMBLE_LEN)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (launch),
        .start_rd (reg_wdata[CMD_RD_BIT]),
        .phy      (reg_wdata[PHY_LSB +: FIELD_W]),
        .regno    (reg_wdata[FIELD_W-1:0]),
        .wdata    (host_q.wdata),
        .rise_ev  (rise_ev),
        .fall_ev  (fall_ev),
        .mdio_i   (mdio_i),
        .busy     (seq_busy),
        .is_rd    (seq_is_rd),
        .done     (seq_done),
        .cap      (seq_cap),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );
endmodule

// File: rtl/mdio_cmd_engine_chk.sv
module mdio_cmd_engine_chk #(
    parameter int HALF_DIV     = 4,
    parameter int PREAMBLE_LEN = 32
) (
    input logic        clk,
    input logic        rst_n,
    input logic        mdc,
    input logic        mdio_oe,
    input logic        wr_flag,
    input logic        rd_flag,
    input logic        reg_wr_en,
    input logic [1:0]  reg_addr,
    input logic [15:0] cmd_word
);
    logic        busy;
    logic        mdc_pq;
    logic [15:0] hcnt;
    logic [15:0] rises;

    assign busy = wr_flag || rd_flag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdc_pq <= 1'b0;
            hcnt   <= '0;
            rises  <= '0;
        end else begin
            mdc_pq <= mdc;
            if (!busy)               hcnt <= '0;
            else if (mdc != mdc_pq)  hcnt <= 16'd1;
            else                     hcnt <= hcnt + 16'd1;
            if (!busy)                                     rises <= '0;
            else if (mdc && !mdc_pq && rises != 16'hFFFF)  rises <= rises + 16'd1;
        end
    end

    p_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    p_half_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (mdc != mdc_pq)) |-> (hcnt == 16'(HALF_DIV)));

    p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_flag && rd_flag));

    p_write_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_flag |-> mdio_oe);

    p_read_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_flag && (rises > 16'(PREAMBLE_LEN + 14))) |-> !mdio_oe);

    p_busy_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr_en && (reg_addr == 2'd0)) |=> $stable(cmd_word));
endmodule

bind mdio_cmd_engine mdio_cmd_engine_chk #(
    .HALF_DIV     (HALF_DIV),
    .PREAMBLE_LEN (PREAMBLE_LEN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mdc       (mdc),
    .mdio_oe   (mdio_oe),
    .wr_flag   (wr_flag_q),
    .rd_flag   (rd_flag_q),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .cmd_word  (cmd_q)
);

// File: tb/mdio_cmd_engine_tb.sv
module mdio_cmd_engine_tb;
    localparam int HALF     = 2;
    localparam int PRE      = 32;
    localparam int FL       = PRE + 32;
    localparam int BUSY_CYC = 2 * FL * HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    always #5 clk = ~clk;

    mdio_cmd_engine #(.HALF_DIV(HALF), .PREAMBLE_LEN(PRE)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int errors = 0;
    int checks = 0;
    int nbits = 0;
    int mdc_bad = 0;
    time last_t = 0;
    logic [FL-1:0] cap_o = '0;
    logic [FL-1:0] cap_oe = '0;
    logic [15:0]   phy_data = '0;

    // PHY responder: record each bit at MDC rise, present next read bit.
    always @(posedge mdc) begin
        if (nbits < FL) begin
            cap_o[FL-1-nbits]  = mdio_o;
            cap_oe[FL-1-nbits] = mdio_oe;
        end
        nbits = nbits + 1;
        if (nbits >= FL - 16 && nbits < FL) mdio_i = phy_data[FL-1-nbits];
        else                                mdio_i = 1'b1;
    end

    always @(posedge mdc or negedge mdc) begin
        if (last_t != 0 && ($time - last_t) != HALF * 10) mdc_bad = mdc_bad + 1;
        last_t = $time;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [15:0] v);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_addr = 2'd0;
    endtask

    task automatic run_frame(input logic [15:0] cmd, input logic [15:0] wd,
                             input logic [15:0] pdat, input int dis_addr,
                             input logic [15:0] dis_data);
        logic rd;
        logic [FL-1:0] ef, eo;
        logic [15:0] first_flags;
        int busy_n;
        rd = cmd[13];
        ef = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), cmd[12:8], cmd[4:0], 2'b10, wd};
        eo = rd ? 64'hFFFF_FFFF_FFFC_0000 : {FL{1'b1}};
        wr_reg(2'd1, wd);
        phy_data = pdat; nbits = 0; last_t = 0; mdc_bad = 0;
        cap_o = '0; cap_oe = '0;
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 2'd0; reg_wdata = cmd;
        @(negedge clk);
        reg_wr_en = 1'b0;
        #1;
        first_flags = reg_rdata & 16'h6000;
        busy_n = 0;
        for (int i = 0; i < 20000; i++) begin
            if (i == 10 && dis_addr >= 0) begin
                reg_wr_en = 1'b1; reg_addr = 2'(dis_addr); reg_wdata = dis_data;
            end
            if (i == 11) begin
                reg_wr_en = 1'b0; reg_addr = 2'd0;
            end
            #1;
            if (i == 10 && dis_addr == 1) busy_n = busy_n + 1;
            else if (reg_rdata[14:13] == 2'b00) break;
            else busy_n = busy_n + 1;
            @(negedge clk);
        end
        chk(first_flags == (rd ? 16'h2000 : 16'h4000), "R4 R7 start flag during frame", 64'(first_flags), 64'(rd ? 16'h2000 : 16'h4000));
        chk(busy_n == BUSY_CYC, "R4 busy duration", 64'(busy_n), 64'(BUSY_CYC));
        chk(nbits == FL, "R5 rising edges per frame", 64'(nbits), 64'(FL));
        chk(mdc_bad == 0, "R5 mdc phase length", 64'(mdc_bad), 64'd0);
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R5 idle after frame", {62'd0, mdc, mdio_oe}, 64'd0);
        chk((cap_o & eo) == (ef & eo), rd ? "R3 read frame bits" : "R2 write frame bits", cap_o & eo, ef & eo);
        chk(cap_oe == eo, rd ? "R3 driver release" : "R2 driver enable", cap_oe, eo);
        chk(reg_rdata == {cmd[15], 2'b00, cmd[12:0]}, "R4 R6 command readback", 64'(reg_rdata), 64'({cmd[15], 2'b00, cmd[12:0]}));
        if (rd) begin
            reg_addr = 2'd2; #1;
            chk(reg_rdata == pdat, "R3 read data", 64'(reg_rdata), 64'(pdat));
            reg_addr = 2'd0;
        end
        if (dis_addr == 1) begin
            reg_addr = 2'd1; #1;
            chk(reg_rdata == dis_data, "R8 write data rewritten", 64'(reg_rdata), 64'(dis_data));
            chk((cap_o & eo) == (ef & eo), "R8 frame kept launch data", cap_o & eo, ef & eo);
            reg_addr = 2'd0;
        end
        repeat (40) @(negedge clk);
        chk(nbits == FL, "R6 no further frame", 64'(nbits), 64'(FL));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL R4 watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins idle", {62'd0, mdc, mdio_oe}, 64'd0);
        for (int a = 0; a < 3; a++) begin
            reg_addr = 2'(a); #1;
            chk(reg_rdata == 16'h0000, "R1 register reset value", 64'(reg_rdata), 64'd0);
        end
        reg_addr = 2'd0;

        // sweep all PHY addresses and register numbers, writes then reads
        for (int p = 0; p < 32; p++) begin
            run_frame(16'h4000 | (16'(p) << 8) | 16'(31 - p),
                      16'(p * 16'h0813) ^ 16'hA5C3, 16'h0000, -1, 16'h0000);
            run_frame(16'h2000 | (16'(p) << 8) | 16'((p * 7) % 32),
                      16'h0000, ~16'(p * 16'h1111 + 3), -1, 16'h0000);
        end

        // R7 both flags run a read
        run_frame(16'h6000 | (16'd5 << 8) | 16'd9, 16'h0F0F, 16'hBEEF, -1, 16'h0000);
        // R6 command during a read frame is dropped
        run_frame(16'h2000 | (16'd3 << 8) | 16'd17, 16'h0000, 16'h8001, 0, 16'h4000 | (16'd20 << 8) | 16'd4);
        // R6 command during a write frame is dropped
        run_frame(16'h4000 | (16'd30 << 8) | 16'd1, 16'h7E81, 16'h0000, 0, 16'h2000 | (16'd2 << 8) | 16'd2);
        // R8 write data rewritten mid-frame
        run_frame(16'h4000 | (16'd9 << 8) | 16'd12, 16'hC3A5, 16'h0000, 1, 16'h1234);

        // R9 command without start flags
        nbits = 0;
        wr_reg(2'd0, 16'h8A05);
        repeat (300) @(negedge clk);
        chk(nbits == 0 && mdc == 1'b0, "R9 no frame started", 64'(nbits), 64'd0);
        #1;
        chk(reg_rdata == 16'h8A05, "R9 word stored without flags", 64'(reg_rdata), 64'h8A05);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule